// File: doc/BRIEF.md
# Cache Maintenance Command Sequencer

This block receives a maintenance command word and applies it to the tag-valid and lock-down state of two set-associative caches: one for instructions and one for data. A command can flush one line, flush a whole cache, unlock one line, unlock a whole cache, or drain the data write buffer. Single-line commands take the way and the set from the line-address inputs, which are sampled with the command. Whole-cache commands walk the sets, one set per clock, and clear all ways of each set together. When both caches are targeted, they are walked side by side.

Each command is checked before it runs. A command with an illegal cache target or a malformed operation field does nothing. It still finishes with a done pulse, and the invalid flag is raised during that pulse. The tag and lock arrays are modelled inside the block. A fill port sets lines for test and integration, and a read port lets the caller inspect any line. The write buffer is represented only by a drain request and an empty handshake.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, busy, done, invalid and wb_drain are low, and every line of both caches is invalid and unlocked.
- R2: Command word encoding. Bit 0 selects the instruction cache and bit 1 selects the data cache. The operation bits are: bit 2 flush whole cache, bit 3 flush one line, bit 4 unlock whole cache, bit 5 unlock one line, bit 6 drain write buffer. Bit 7 is reserved. A command is taken when cmd_valid is high and busy is low.
- R3: A command is invalid if it has no cache-select bit, if it does not have exactly one operation bit, or if bit 7 is set. In the cycle after it is taken, done and invalid are high, busy stays low, and no line changes.
- R4: A single-line flush or a single-line unlock with both cache-select bits set is invalid and changes nothing.
- R5: A drain is invalid if the data-cache select bit is clear or the instruction-cache select bit is set.
- R6: A single-line flush clears the valid bit and the lock bit of the addressed way and set in the selected cache. done is high in the cycle after the command is taken, and busy stays low.
- R7: A single-line unlock clears only the lock bit of the addressed line. The valid bit keeps its value.
- R8: A whole-cache flush clears the valid and lock bits of every line in each selected cache, including locked lines. It leaves an unselected cache untouched. Busy is high for SETS cycles, and done rises SETS+1 cycles after the command is taken.
- R9: A whole-cache unlock clears every lock bit in each selected cache and leaves all valid bits unchanged. Its timing is the same as in R8.
- R10: During a drain, busy and wb_drain stay high until wb_empty is sampled high. done is high in the cycle after that sample.
- R11: A command presented while busy is high is ignored.
- R12: done lasts one cycle for each command. invalid is high only together with done.
- R13: A fill sets the addressed line valid and loads its lock bit from fill_lock. The read port returns the valid and lock bits of the addressed line combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_word | input | 8 | Command word (see R2) |
| line_way | input | WAY_W | Way for single-line commands |
| line_set | input | SET_W | Set index for single-line commands |
| wb_empty | input | 1 | Write buffer reports empty |
| fill_en | input | 1 | Fill strobe |
| fill_dcache | input | 1 | Fill targets the data cache when high |
| fill_set | input | SET_W | Fill set index |
| fill_way | input | WAY_W | Fill way |
| fill_lock | input | 1 | Lock bit written by a fill |
| rd_dcache | input | 1 | Read port targets the data cache when high |
| rd_set | input | SET_W | Read set index |
| rd_way | input | WAY_W | Read way |
| rd_valid | output | 1 | Valid bit of the read line |
| rd_lock | output | 1 | Lock bit of the read line |
| wb_drain | output | 1 | Drain request to the write buffer |
| busy | output | 1 | A walk or drain is in progress |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Completed command was rejected |

## Verification
The cycle in which a command is taken is called cycle 0. Invalid and single-line commands report done in cycle 1. Whole-cache walks report done in cycle SETS+1. A drain reports done one cycle after wb_empty is first sampled high. The bench counts falling edges from the edge where the command is taken and compares the count with these figures. All outputs are sampled on the falling edge, half a period away from the edge that updates them. After every done pulse, the bench checks that done has dropped. It then reads every line of both caches through the read port and compares it with a reference model. The model is updated only for commands the bench judges legal, so a command that changed state wrongly, including one presented while busy, shows up as a mismatch.

// File: rtl/cache_maint_seq.sv
module cache_maint_seq #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_word,
  input  logic [WAY_W-1:0] line_way,
  input  logic [SET_W-1:0] line_set,
  input  logic             wb_empty,
  input  logic             fill_en,
  input  logic             fill_dcache,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             fill_lock,
  input  logic             rd_dcache,
  input  logic [SET_W-1:0] rd_set,
  input  logic [WAY_W-1:0] rd_way,
  output logic             rd_valid,
  output logic             rd_lock,
  output logic             wb_drain,
  output logic             busy,
  output logic             done,
  output logic             invalid
);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DRAIN} st_t;
  st_t st;

  logic [SET_W-1:0] idx;
  logic walk_flush, walk_ic, walk_dc;
  logic [SETS-1:0][WAYS-1:0] iv, il, dv, dl;

  wire sel_ic = cmd_word[0];
  wire sel_dc = cmd_word[1];
  wire op_fla = cmd_word[2];
  wire op_fls = cmd_word[3];
  wire op_ula = cmd_word[4];
  wire op_uls = cmd_word[5];
  wire op_drn = cmd_word[6];

  wire bad = cmd_word[7] || !(sel_ic || sel_dc) || !$onehot(cmd_word[6:2]) ||
             ((op_fls || op_uls) && sel_ic && sel_dc) ||
             (op_drn && (sel_ic || !sel_dc));

  assign busy     = (st != S_IDLE);
  assign wb_drain = (st == S_DRAIN);
  assign rd_valid = rd_dcache ? dv[rd_set][rd_way] : iv[rd_set][rd_way];
  assign rd_lock  = rd_dcache ? dl[rd_set][rd_way] : il[rd_set][rd_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= '0;
      walk_flush <= 1'b0;
      walk_ic    <= 1'b0;
      walk_dc    <= 1'b0;
      done       <= 1'b0;
      invalid    <= 1'b0;
      iv <= '0; il <= '0; dv <= '0; dl <= '0;
    end else begin
      done    <= 1'b0;
      invalid <= 1'b0;

      if (fill_en) begin
        if (fill_dcache) begin
          dv[fill_set][fill_way] <= 1'b1;
          dl[fill_set][fill_way] <= fill_lock;
        end else begin
          iv[fill_set][fill_way] <= 1'b1;
          il[fill_set][fill_way] <= fill_lock;
        end
      end

      case (st)
        S_IDLE: if (cmd_valid) begin
          if (bad) begin
            done    <= 1'b1;
            invalid <= 1'b1;
          end else if (op_fls || op_uls) begin
            if (sel_dc) begin
              dl[line_set][line_way] <= 1'b0;
              if (op_fls) dv[line_set][line_way] <= 1'b0;
            end
            if (sel_ic) begin
              il[line_set][line_way] <= 1'b0;
              if (op_fls) iv[line_set][line_way] <= 1'b0;
            end
            done <= 1'b1;
          end else if (op_fla || op_ula) begin
            st         <= S_WALK;
            idx        <= '0;
            walk_flush <= op_fla;
            walk_ic    <= sel_ic;
            walk_dc    <= sel_dc;
          end else begin
            st <= S_DRAIN;
          end
        end
        S_WALK: begin
          if (walk_ic) begin
            il[idx] <= '0;
            if (walk_flush) iv[idx] <= '0;
          end
          if (walk_dc) begin
            dl[idx] <= '0;
            if (walk_flush) dv[idx] <= '0;
          end
          idx <= idx + 1'b1;
          if (idx == LAST_SET) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        S_DRAIN: if (wb_empty) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_maint_seq_chk.sv
module cache_maint_seq_chk #(
  parameter int SETS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic wb_empty,
  input logic wb_drain,
  input logic busy,
  input logic done,
  input logic invalid
);
  int walk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) walk_cnt <= 0;
    else walk_cnt <= (busy && !wb_drain) ? walk_cnt + 1 : 0;
  end

  AST_INVALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> done); // R12
  AST_INVALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> !busy); // R3
  AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R8
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid)); // R11
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_drain && !wb_empty) |=> (wb_drain && !done)); // R10
  AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wb_drain) |-> done); // R10
  AST_WALK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(wb_drain)) |-> (walk_cnt == SETS)); // R8
endmodule

bind cache_maint_seq cache_maint_seq_chk #(.SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wb_empty(wb_empty),
  .wb_drain(wb_drain), .busy(busy), .done(done), .invalid(invalid)
);

// File: tb/tb_cache_maint_seq.sv
`timescale 1ns/1ps
module tb_cache_maint_seq;
  localparam int SETS = 16;
  localparam int WAYS = 4;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [7:0] IC = 8'h01, DC = 8'h02, FLA = 8'h04, FLS = 8'h08,
                         ULA = 8'h10, ULS = 8'h20, DRN = 8'h40;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_word = 0;
  logic [WAY_W-1:0] line_way = 0;
  logic [SET_W-1:0] line_set = 0;
  logic wb_empty = 0;
  logic fill_en = 0, fill_dcache = 0, fill_lock = 0;
  logic [SET_W-1:0] fill_set = 0;
  logic [WAY_W-1:0] fill_way = 0;
  logic rd_dcache = 0;
  logic [SET_W-1:0] rd_set = 0;
  logic [WAY_W-1:0] rd_way = 0;
  logic rd_valid, rd_lock, wb_drain, busy, done, invalid;

  int total = 0, bad = 0;
  bit mv [2][SETS][WAYS];
  bit ml [2][SETS][WAYS];

  always #2.5 clk = ~clk;

  cache_maint_seq #(.SETS(SETS), .WAYS(WAYS)) dut (.*);

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bad(logic [7:0] w);
    bit ic = w[0], dc = w[1];
    if (w[7] || !(ic || dc) || $countones(w[6:2]) != 1) return 1;
    if ((w[3] || w[5]) && ic && dc) return 1;
    if (w[6] && (ic || !dc)) return 1;
    return 0;
  endfunction

  task automatic model_apply(logic [7:0] w, int way, int set);
    for (int c = 0; c < 2; c++) begin
      if (!(c == 0 ? w[0] : w[1])) continue;
      if (w[3]) begin mv[c][set][way] = 0; ml[c][set][way] = 0; end
      if (w[5]) ml[c][set][way] = 0;
      for (int s = 0; s < SETS; s++)
        for (int k = 0; k < WAYS; k++) begin
          if (w[2]) begin mv[c][s][k] = 0; ml[c][s][k] = 0; end
          if (w[4]) ml[c][s][k] = 0;
        end
    end
  endtask

  task automatic verify_state(string req);
    int errs = 0;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < SETS; s++)
        for (int k = 0; k < WAYS; k++) begin
          rd_dcache = c[0]; rd_set = s[SET_W-1:0]; rd_way = k[WAY_W-1:0];
          #0.1;
          if (rd_valid !== mv[c][s][k] || rd_lock !== ml[c][s][k]) errs++;
        end
    check(errs == 0, req, "line state mismatches", errs, 0);
  endtask

  task automatic fill(int c, int s, int k, bit lk);
    @(negedge clk);
    fill_en = 1; fill_dcache = c[0]; fill_set = s[SET_W-1:0];
    fill_way = k[WAY_W-1:0]; fill_lock = lk;
    @(negedge clk);
    fill_en = 0;
    mv[c][s][k] = 1; ml[c][s][k] = lk;
  endtask

  task automatic random_fill(int n);
    for (int i = 0; i < n; i++)
      fill($urandom_range(1), $urandom_range(SETS-1), $urandom_range(WAYS-1),
           1'($urandom_range(1)));
  endtask

  task automatic run_cmd(logic [7:0] w, int way, int set, int dwait, string req);
    bit eb = exp_bad(w);
    int n;
    wb_empty = 0;
    @(negedge clk);
    cmd_word = w; line_way = way[WAY_W-1:0]; line_set = set[SET_W-1:0];
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    n = 1;
    if (eb || w[3] || w[5]) begin
      check(done == 1 && busy == 0, req, "done in cycle 1 without busy",
            {busy, done}, 1);
      check(invalid == eb, req, "invalid flag", invalid, eb);
    end else if (w[2] || w[4]) begin
      while (!done && n < SETS + 4) begin
        if (n == 2) begin cmd_word = IC | DC | FLA; cmd_valid = 1; end
        if (n == 3) cmd_valid = 0;
        @(negedge clk); n++;
      end
      cmd_valid = 0;
      check(done == 1 && n == SETS + 1, req, "walk done cycle", n, SETS + 1);
      check(invalid == 0, req, "invalid on walk", invalid, 0);
    end else begin
      for (int i = 0; i < dwait; i++) begin
        cmd_word = IC | DC | FLA; cmd_valid = (i == 0);
        check(busy && wb_drain && !done, req, "drain held while not empty",
              {busy, wb_drain, done}, 6);
        @(negedge clk);
      end
      cmd_valid = 0;
      wb_empty = 1;
      @(negedge clk);
      check(done == 1 && invalid == 0 && busy == 0, req, "drain done after empty",
            {done, invalid, busy}, 4);
      wb_empty = 0;
    end
    if (!eb) model_apply(w, way, set);
    @(negedge clk);
    check(done == 0 && invalid == 0, "R12", "done pulse one cycle", done, 0);
    verify_state(req);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4411));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0 && invalid == 0 && wb_drain == 0, "R1",
          "outputs after reset", {busy, done, invalid, wb_drain}, 0);
    verify_state("R1");

    fill(1, 5, 2, 1); fill(0, 7, 1, 1); fill(0, 7, 3, 0);
    verify_state("R13");
    random_fill(40);
    run_cmd(FLS | DC, 2, 5, 0, "R6");
    run_cmd(ULS | IC, 1, 7, 0, "R7");
    run_cmd(FLS | IC | DC, 3, 7, 0, "R4");
    run_cmd(ULS | IC | DC, 1, 7, 0, "R4");
    run_cmd(FLA, 0, 0, 0, "R3");
    run_cmd(FLA | ULA | IC, 0, 0, 0, "R3");
    run_cmd(8'h80 | FLA | IC, 0, 0, 0, "R3");
    run_cmd(DRN | DC | IC, 0, 0, 0, "R5");
    run_cmd(DRN | IC, 0, 0, 0, "R5");
    run_cmd(FLA | IC, 0, 0, 0, "R8");
    random_fill(40);
    run_cmd(FLA | IC | DC, 0, 0, 0, "R8");
    random_fill(40);
    run_cmd(ULA | DC, 0, 0, 0, "R9");
    run_cmd(ULA | IC | DC, 0, 0, 0, "R9");
    run_cmd(DRN | DC, 0, 0, 3, "R10");
    run_cmd(DRN | DC, 0, 0, 0, "R10");
    random_fill(30);
    run_cmd(DRN | DC, 0, 0, 2, "R11");

    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      int op = $urandom_range(6);
      case (op)
        0: w = FLS; 1: w = FLA; 2: w = ULS; 3: w = ULA; 4: w = DRN;
        5: w = ULS | FLS;
        default: w = 8'($urandom_range(255));
      endcase
      if (op != 6) w = w | 8'($urandom_range(3));
      random_fill(6);
      run_cmd(w, $urandom_range(WAYS-1), $urandom_range(SETS-1),
              $urandom_range(4), "R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule